// File: doc/BRIEF.md
# Target Raster and Kernel Walk Sequencer

This block sequences the target side of an image resampling or filtering engine. After a start request it places a target coordinate pair (u, v) at the lower corner of a programmable rectangle. At each location it runs one complete kernel walk, one tap per clock. For every tap it emits an 8-bit coefficient address for an external lookup RAM. The pair moves on only after the last tap of the walk. Within a row, u climbs from its lower limit to one past its upper limit. It then returns to the lower limit while v advances by one.

Two address formats are supported. In filtering mode the whole address is the walk counter, so up to 256 coefficients are reachable, which covers a 16x16 kernel. In resampling mode a 4-bit fractional offset supplied by the source-address logic fills the upper nibble and the walk counter fills the lower nibble. The kernel is then at most 4x4. When the final walk of the rectangle ends, a one-cycle frame-end pulse is raised and the sequence restarts at the lower corner on its own.

Top module: `raster_walk_seq`

## Requirements
- R1: Out of reset, `valid` and `frame_end` are low and stay low until `start` is sampled high.
- R2: One cycle after `start` is sampled, `valid` is high, (u, v) equals (`u_lo`, `v_lo`) and the walk counter is 0. From then on `valid` stays high on every cycle.
- R3: The walk counter rises by one per clock from 0 to taps-1 and then returns to 0. In filtering mode taps is (`ksize_m1`+1)^2.
- R4: u and v stay constant on every cycle of a walk except the cycle that follows the final tap.
- R5: After the final tap at (u, v), u becomes u+1 when u is below `u_hi`+1. Otherwise u becomes `u_lo` and v becomes v+1, unless v already equals `v_hi`+1.
- R6: `frame_end` is high for exactly the cycle of the final tap at (`u_hi`+1, `v_hi`+1). On the next cycle the output is (`u_lo`, `v_lo`) with the walk counter at 0.
- R7: In resampling mode (`resample`=1), `coef_addr[7:4]` equals `frac` and `coef_addr[3:0]` is the walk counter. The side length is `ksize_m1[1:0]`+1, so taps is at most 16.
- R8: In filtering mode (`resample`=0), `coef_addr[7:0]` is the walk counter, and `ksize_m1`=15 gives 256 taps.
- R9: A `start` sampled in the middle of a sequence abandons it. The next cycle shows the newly loaded lower corner with the walk counter at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Synchronous start or restart of the sequence |
| u_lo | input | CW | Lower limit of u |
| u_hi | input | CW | Upper limit of u; the row ends at u_hi+1 |
| v_lo | input | CW | Lower limit of v |
| v_hi | input | CW | Upper limit of v; the frame ends at v_hi+1 |
| ksize_m1 | input | 4 | Kernel side length minus one |
| resample | input | 1 | 1 selects resampling mode, 0 selects filtering mode |
| frac | input | 4 | Fractional offset placed in the upper address nibble in resampling mode |
| valid | output | 1 | Qualifies u, v and coef_addr |
| u | output | CW | Current target column |
| v | output | CW | Current target row |
| coef_addr | output | 8 | Coefficient RAM address for the current tap |
| frame_end | output | 1 | One-cycle pulse on the final tap of the frame |

## Verification
A walk counter that loses its count shows on the very next cycle as a wrong low address byte. The tap length and the moment the pair moves then drift, and (u, v) is out of step within one kernel length. A fault in the row or column counter appears when the first walk ends, as a wrong target pair. A misplaced end comparison shows when a row or the frame ends, as a missing, early or doubled frame-end pulse, or as a wrong restart corner on the following cycle. Each configuration is swept cycle by cycle through more than one full frame, so every wrap point is compared at least twice.

// File: rtl/rsq_pkg.sv
package rsq_pkg;
  localparam int ADDR_W = 8;
  localparam int NIB_W  = 4;
  localparam int KSZ_W  = 4;
  typedef enum logic {
    MODE_FILTER   = 1'b0,
    MODE_RESAMPLE = 1'b1
  } addr_mode_e;
endpackage

// File: rtl/rsq_walk_ctr.sv
module rsq_walk_ctr
  import rsq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              en,
  input  logic [KSZ_W-1:0]  ksize_m1,
  input  addr_mode_e        mode,
  output logic [ADDR_W-1:0] walk,
  output logic              tap_last
);
  localparam int SIDE_W = KSZ_W + 1;
  localparam int TAPS_W = 2 * SIDE_W;

  logic [SIDE_W-1:0] side;
  logic [TAPS_W-1:0] taps;
  logic [ADDR_W-1:0] walk_q, walk_d;
  logic              walk_ce;

  // side length: resampling keeps only two size bits (4x4 at most)
  always_comb begin
    if (mode == MODE_RESAMPLE)
      side = SIDE_W'(ksize_m1[1:0]) + SIDE_W'(1);
    else
      side = SIDE_W'(ksize_m1) + SIDE_W'(1);
    taps = TAPS_W'(side) * TAPS_W'(side);
  end

  assign tap_last = (TAPS_W'(walk_q) == taps - TAPS_W'(1));

  always_comb begin
    walk_ce = clr | en;
    if (clr)
      walk_d = '0;
    else if (tap_last)
      walk_d = '0;
    else
      walk_d = walk_q + ADDR_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      walk_q <= '0;
    else if (walk_ce)
      walk_q <= walk_d;
  end

  assign walk = walk_q;
endmodule

// File: rtl/rsq_axis.sv
module rsq_axis #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         step,
  input  logic [W-1:0] lo,
  input  logic [W-1:0] hi,
  output logic [W-1:0] pos,
  output logic         at_end
);
  logic [W-1:0] pos_q, pos_d;
  logic         pos_ce;

  // the range runs one past the upper limit
  assign at_end = (pos_q == hi + W'(1));

  always_comb begin
    pos_ce = load | step;
    if (load)
      pos_d = lo;
    else if (at_end)
      pos_d = lo;
    else
      pos_d = pos_q + W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      pos_q <= '0;
    else if (pos_ce)
      pos_q <= pos_d;
  end

  assign pos = pos_q;
endmodule

// File: rtl/rsq_addr_fmt.sv
module rsq_addr_fmt
  import rsq_pkg::*;
(
  input  addr_mode_e        mode,
  input  logic [NIB_W-1:0]  frac,
  input  logic [ADDR_W-1:0] walk,
  output logic [ADDR_W-1:0] addr
);
  localparam int LO_W = ADDR_W - NIB_W;

  generate
    if (LO_W > 0) begin : g_split
      always_comb begin
        if (mode == MODE_RESAMPLE)
          addr = {frac, walk[LO_W-1:0]};
        else
          addr = walk;
      end
    end else begin : g_flat
      assign addr = walk;
    end
  endgenerate
endmodule

// File: rtl/raster_walk_seq.sv
module raster_walk_seq
  import rsq_pkg::*;
#(
  parameter int CW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [CW-1:0]     u_lo,
  input  logic [CW-1:0]     u_hi,
  input  logic [CW-1:0]     v_lo,
  input  logic [CW-1:0]     v_hi,
  input  logic [KSZ_W-1:0]  ksize_m1,
  input  logic              resample,
  input  logic [NIB_W-1:0]  frac,
  output logic              valid,
  output logic [CW-1:0]     u,
  output logic [CW-1:0]     v,
  output logic [ADDR_W-1:0] coef_addr,
  output logic              frame_end
);
  addr_mode_e        mode;
  logic              run_q, run_d, run_ce;
  logic [ADDR_W-1:0] walk;
  logic              tap_last;
  logic              adv;
  logic              u_end, v_end;
  logic              u_step, v_step;

  assign mode = addr_mode_e'(resample);

  always_comb begin
    run_ce = start;
    run_d  = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      run_q <= 1'b0;
    else if (run_ce)
      run_q <= run_d;
  end

  assign adv    = run_q & tap_last;
  assign u_step = adv & ~start;
  assign v_step = adv & u_end & ~start;

  rsq_walk_ctr u_walk (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (start),
    .en       (run_q),
    .ksize_m1 (ksize_m1),
    .mode     (mode),
    .walk     (walk),
    .tap_last (tap_last)
  );

  rsq_axis #(.W(CW)) u_col (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (start),
    .step   (u_step),
    .lo     (u_lo),
    .hi     (u_hi),
    .pos    (u),
    .at_end (u_end)
  );

  rsq_axis #(.W(CW)) u_row (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (start),
    .step   (v_step),
    .lo     (v_lo),
    .hi     (v_hi),
    .pos    (v),
    .at_end (v_end)
  );

  rsq_addr_fmt u_fmt (
    .mode (mode),
    .frac (frac),
    .walk (walk),
    .addr (coef_addr)
  );

  assign valid     = run_q;
  assign frame_end = adv & u_end & v_end;
endmodule

// File: rtl/raster_walk_seq_chk.sv
module raster_walk_seq_chk #(
  parameter int CW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic [CW-1:0] u_lo,
  input logic [CW-1:0] v_lo,
  input logic          resample,
  input logic [3:0]    frac,
  input logic          valid,
  input logic [CW-1:0] u,
  input logic [CW-1:0] v,
  input logic [7:0]    coef_addr,
  input logic          frame_end,
  input logic          tap_last
);
  p_idle_until_start_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(valid) |-> $past(start));

  p_start_loads_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (valid && u == $past(u_lo) && v == $past(v_lo) && coef_addr[3:0] == 4'd0));

  p_hold_in_walk_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !start && !tap_last) |=> ($stable(u) && $stable(v)));

  p_end_restart_r6: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |=> (valid && u == $past(u_lo) && v == $past(v_lo)));

  p_end_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |=> !frame_end);

  p_end_on_last_tap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |-> (valid && tap_last));

  p_frac_nibble_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && resample) |-> (coef_addr[7:4] == frac));
endmodule

bind raster_walk_seq raster_walk_seq_chk #(.CW(CW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .u_lo      (u_lo),
  .v_lo      (v_lo),
  .resample  (resample),
  .frac      (frac),
  .valid     (valid),
  .u         (u),
  .v         (v),
  .coef_addr (coef_addr),
  .frame_end (frame_end),
  .tap_last  (tap_last)
);

// File: tb/raster_walk_seq_bench.sv
module raster_walk_seq_bench;
  localparam int CW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [CW-1:0] u_lo = '0, u_hi = '0, v_lo = '0, v_hi = '0;
  logic [3:0]    ksize_m1 = '0;
  logic          resample = 1'b0;
  logic [3:0]    frac = '0;
  logic          valid;
  logic [CW-1:0] u, v;
  logic [7:0]    coef_addr;
  logic          frame_end;

  int n_checks = 0;
  int n_fails  = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  raster_walk_seq #(.CW(CW)) u_raster_walk_seq (
    .clk(clk), .rst_n(rst_n), .start(start),
    .u_lo(u_lo), .u_hi(u_hi), .v_lo(v_lo), .v_hi(v_hi),
    .ksize_m1(ksize_m1), .resample(resample), .frac(frac),
    .valid(valid), .u(u), .v(v), .coef_addr(coef_addr), .frame_end(frame_end)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // drive a configuration, start it, compare every cycle for ncyc cycles
  task automatic run_cfg(input int ul, input int uh, input int vl, input int vh,
                         input int k, input bit rs, input int fr,
                         input int ncyc, input bit mid);
    int eu, ev, ew, taps, side, ea;
    bit ed;
    @(negedge clk);
    u_lo = CW'(ul); u_hi = CW'(uh); v_lo = CW'(vl); v_hi = CW'(vh);
    ksize_m1 = 4'(k); resample = rs; frac = 4'(fr);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    side = rs ? ((k % 4) + 1) : (k + 1);
    taps = side * side;
    eu = ul; ev = vl; ew = 0;
    for (int c = 0; c < ncyc; c++) begin
      ea = rs ? ((fr << 4) | (ew % 16)) : ew;
      ed = (ew == taps - 1) && (eu == uh + 1) && (ev == vh + 1);
      if (c == 0) begin
        if (mid) chk(u == CW'(ul) && v == CW'(vl) && coef_addr == 8'(ea), "R9", int'(u), ul);
        else     chk(u == CW'(ul) && v == CW'(vl) && coef_addr == 8'(ea), "R2", int'(u), ul);
      end
      chk(valid == 1'b1, "R2", int'(valid), 1);
      if (ew == 0) begin
        chk(u == CW'(eu), "R5 u", int'(u), eu);
        chk(v == CW'(ev), "R5 v", int'(v), ev);
      end else begin
        chk(u == CW'(eu) && v == CW'(ev), "R4", int'(u), eu);
      end
      if (rs) begin
        chk(coef_addr[7:4] == 4'(fr), "R7 frac", int'(coef_addr[7:4]), fr);
        chk(coef_addr[3:0] == 4'(ew), "R7 walk", int'(coef_addr[3:0]), ew);
      end else if (k == 15) begin
        chk(coef_addr == 8'(ew), "R8", int'(coef_addr), ew);
      end else begin
        chk(coef_addr == 8'(ew), "R3", int'(coef_addr), ew);
      end
      chk(frame_end == ed, "R6", int'(frame_end), int'(ed));
      // advance the reference
      if (ew == taps - 1) begin
        ew = 0;
        if (eu == uh + 1) begin
          eu = ul;
          if (ev == vh + 1) ev = vl;
          else ev = ev + 1;
        end else begin
          eu = eu + 1;
        end
      end else begin
        ew = ew + 1;
      end
      @(negedge clk);
    end
  endtask

  initial begin
    #(200000 * 8);
    if (!finished) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk(valid == 1'b0, "R1 valid", int'(valid), 0);
      chk(frame_end == 1'b0, "R1 frame_end", int'(frame_end), 0);
    end
    // filtering, 3x3 kernel, 4 columns x 3 rows, two frames and a bit
    run_cfg(3, 5, 10, 11, 2, 1'b0, 0, 2 * 9 * 12 + 5, 1'b0);
    // resampling with a 2x2 kernel, upper size bits ignored
    run_cfg(7, 8, 0, 1, 5, 1'b1, 10, 2 * 4 * 9 + 3, 1'b0);
    // filtering, full 16x16 kernel over 2x2 locations
    run_cfg(0, 0, 0, 0, 15, 1'b0, 3, 2 * 256 * 4 + 2, 1'b0);
    // resampling, largest 4x4 kernel
    run_cfg(20, 21, 30, 30, 15, 1'b1, 5, 2 * 16 * 6 + 2, 1'b0);
    // filtering single tap: each cycle moves the pair
    run_cfg(1, 3, 2, 3, 0, 1'b0, 0, 2 * 12 + 3, 1'b0);
    // interrupt a sequence part way, then restart with new limits
    run_cfg(0, 3, 0, 3, 3, 1'b0, 0, 37, 1'b0);
    run_cfg(9, 10, 4, 4, 1, 1'b1, 12, 2 * 4 * 6 + 2, 1'b1);
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule